// File: doc/BRIEF.md
# Prioritized Interrupt and Privilege Controller

This block keeps the processor's privilege level (0 = system, 1 = user) and eight interrupt request lines. Requests come from external lines or from a software interrupt that names a 3-bit vector number. Each request is latched into a sticky pending bit. While the processor runs in user privilege and at least one bit is pending, the controller takes the lowest-numbered pending request. Taking a request saves the current program counter in an interrupt-PC register, drops the privilege level to system, clears that pending bit, and hands the processor a fixed vector address as the next PC. Because interrupts are taken only in user privilege and taking one moves to system privilege, interrupts never nest. A request raised during system privilege waits until user privilege resumes.

A return strobe sends the processor back to the saved PC and restores user privilege. A write port and a read port give access to the interrupt-PC register. Redirects reach the processor through a one-cycle load pulse and a target address. A take pulse with the vector number marks each accepted interrupt.

Top module: `irq_priv_ctrl`

## Requirements
- R1: After reset the privilege level is system (0). No bit is pending, take and pc_load are low, and the interrupt-PC register reads 0.
- R2: A high bit on ext_req sets the pending bit of the same index (bit n for line n) at the next clock edge. That bit stays set, even after the input falls, until its interrupt is taken.
- R3: When sw_req is high, the pending bit whose index equals sw_vec is set at the next edge. This works for every vector 0..7, including one raised on ext_req in the same cycle.
- R4: An interrupt is taken only at an edge where the privilege level before the edge is user (1). In system privilege no take occurs and every pending bit is held.
- R5: When several bits are pending, the lowest index is taken first. take_vec gives that index as an unsigned binary number.
- R6: At the edge that takes interrupt n, take pulses high for one cycle. The privilege level becomes system, the interrupt-PC register captures cur_pc, and pending bit n clears unless it is requested again in the same cycle.
- R7: With the take pulse, pc_load is high and pc_target equals 0x0010 + 4*n. Line 7 gives 0x002C.
- R8: A reti strobe with no take at the same edge sets the privilege level to user. It also pulses pc_load for one cycle with pc_target equal to the interrupt-PC value held before that edge.
- R9: ipc_wr loads ipc_wdata into the interrupt-PC register, and ipc_rdata shows the register at all times. A take at the same edge wins over the write.
- R10: A take and a reti strobe at the same edge resolve in favour of the take. The privilege level goes to system and pc_target is the vector address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req | input | 8 | External request lines, bit n for line n |
| sw_req | input | 1 | Software interrupt strobe |
| sw_vec | input | 3 | Vector number of the software interrupt |
| cur_pc | input | 16 | PC to save when an interrupt is taken |
| reti | input | 1 | Return-from-interrupt strobe |
| ipc_wr | input | 1 | Write strobe for the interrupt-PC register |
| ipc_wdata | input | 16 | Data for the interrupt-PC register |
| ipc_rdata | output | 16 | Current interrupt-PC register value |
| priv | output | 1 | Privilege level, 0 system, 1 user |
| pending | output | 8 | Sticky pending bits |
| take | output | 1 | One-cycle pulse for an accepted interrupt |
| take_vec | output | 3 | Number of the accepted interrupt |
| pc_load | output | 1 | One-cycle pulse: processor must load pc_target |
| pc_target | output | 16 | Redirect address: vector or saved PC |

## Verification
A take can fall in the same cycle as a return strobe and an interrupt-PC write, and both of those want to change the same state. The bench sets this up by latching a request while already in user privilege. In the next cycle it drives reti and ipc_wr with a value different from cur_pc. It then checks that the privilege level went to system, that the vector address appeared, and that the register holds cur_pc and not the written data. Requests raised during system privilege while several are pending are also checked: each return must release exactly one interrupt, in order of priority.

// File: rtl/irq_priv_ctrl.sv
module irq_priv_ctrl #(
  parameter int PC_W = 16,
  parameter int LINES = 8,
  parameter int VEC_W = $clog2(LINES),
  parameter logic [PC_W-1:0] VEC_BASE = 16'h0010,
  parameter int VEC_STRIDE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] ext_req,
  input  logic             sw_req,
  input  logic [VEC_W-1:0] sw_vec,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic             reti,
  input  logic             ipc_wr,
  input  logic [PC_W-1:0]  ipc_wdata,
  output logic [PC_W-1:0]  ipc_rdata,
  output logic             priv,
  output logic [LINES-1:0] pending,
  output logic             take,
  output logic [VEC_W-1:0] take_vec,
  output logic             pc_load,
  output logic [PC_W-1:0]  pc_target
);

  logic [LINES-1:0] pend_q, req_set, take_mask;
  logic [VEC_W-1:0] sel;
  logic [PC_W-1:0]  ipc_q, tgt_q, vec_addr;
  logic             priv_q, take_q, load_q, can_take;
  logic [VEC_W-1:0] vec_q;

  always_comb begin
    sel = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (pend_q[i]) sel = VEC_W'(i);
  end

  always_comb begin
    req_set = ext_req;
    if (sw_req) req_set[sw_vec] = 1'b1;
  end

  assign can_take  = priv_q && (|pend_q);
  assign take_mask = can_take ? (LINES'(1) << sel) : '0;
  assign vec_addr  = VEC_BASE + PC_W'(VEC_STRIDE) * PC_W'(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      priv_q <= 1'b0;
      ipc_q  <= '0;
      tgt_q  <= '0;
      vec_q  <= '0;
      take_q <= 1'b0;
      load_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~take_mask) | req_set;
      take_q <= can_take;
      load_q <= can_take | reti;
      if (can_take) begin
        priv_q <= 1'b0;
        ipc_q  <= cur_pc;
        vec_q  <= sel;
        tgt_q  <= vec_addr;
      end else begin
        if (reti) begin
          priv_q <= 1'b1;
          tgt_q  <= ipc_q;
        end
        if (ipc_wr) ipc_q <= ipc_wdata;
      end
    end
  end

  assign ipc_rdata = ipc_q;
  assign priv      = priv_q;
  assign pending   = pend_q;
  assign take      = take_q;
  assign take_vec  = vec_q;
  assign pc_load   = load_q;
  assign pc_target = tgt_q;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  p_take_from_user_r4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    take |-> $past(priv_q));

  p_take_enters_system_r6: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    take |-> (!priv_q && ipc_q == $past(cur_pc)));

  p_vector_addr_r7: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    take |-> (pc_load && pc_target == VEC_BASE + PC_W'(VEC_STRIDE) * PC_W'(take_vec)));

  p_reti_restores_r8: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ($past(reti) && !$past(priv_q)) |-> (priv_q && pc_load && pc_target == $past(ipc_q)));

  p_pending_held_r2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !take |-> ((pend_q & $past(pend_q)) == $past(pend_q)));

  p_no_take_in_system_r10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$past(priv_q) |-> !take);

  p_lowest_first_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    take |-> (($past(pend_q) & ((LINES'(1) << take_vec) - LINES'(1))) == '0));

endmodule

// File: tb/irq_priv_ctrl_tb.sv
module irq_priv_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ext_req = '0;
  logic        sw_req = 1'b0;
  logic [2:0]  sw_vec = '0;
  logic [15:0] cur_pc = '0;
  logic        reti = 1'b0;
  logic        ipc_wr = 1'b0;
  logic [15:0] ipc_wdata = '0;
  logic [15:0] ipc_rdata, pc_target;
  logic        priv, take, pc_load;
  logic [7:0]  pending;
  logic [2:0]  take_vec;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_priv_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .sw_req(sw_req), .sw_vec(sw_vec),
    .cur_pc(cur_pc), .reti(reti), .ipc_wr(ipc_wr), .ipc_wdata(ipc_wdata),
    .ipc_rdata(ipc_rdata), .priv(priv), .pending(pending), .take(take),
    .take_vec(take_vec), .pc_load(pc_load), .pc_target(pc_target)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    ext_req = '0; sw_req = 1'b0; reti = 1'b0; ipc_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 priv", priv, 0);
    chk("R1 pending", pending, 0);
    chk("R1 take", take, 0);
    chk("R1 pc_load", pc_load, 0);
    chk("R1 ipc", ipc_rdata, 0);
  endtask

  task automatic t_held_then_taken();
    ext_req = 8'h20; step();
    chk("R2 pending set", pending, 8'h20);
    step(); step();
    chk("R2 pending sticky", pending, 8'h20);
    chk("R4 no take in system", take, 0);
    ipc_wdata = 16'h1234; ipc_wr = 1'b1; step();
    chk("R9 ipc write", ipc_rdata, 16'h1234);
    cur_pc = 16'h0400;
    reti = 1'b1; step();
    chk("R8 priv user", priv, 1);
    chk("R8 pc_load", pc_load, 1);
    chk("R8 target", pc_target, 16'h1234);
    chk("R8 no take yet", take, 0);
    step();
    chk("R6 take", take, 1);
    chk("R5 vec", take_vec, 5);
    chk("R7 target", pc_target, 16'h0024);
    chk("R7 pc_load", pc_load, 1);
    chk("R6 ipc", ipc_rdata, 16'h0400);
    chk("R6 priv", priv, 0);
    chk("R6 pending clr", pending, 0);
    step();
    chk("R6 take pulse", take, 0);
    chk("R6 load pulse", pc_load, 0);
  endtask

  task automatic t_priority();
    ext_req = 8'b1001_0100; sw_req = 1'b1; sw_vec = 3'd6; step();
    chk("R3 sw pending", pending, 8'hD4);
    reti = 1'b1; step();
    step();
    chk("R5 first", take_vec, 2);
    chk("R7 line2", pc_target, 16'h0018);
    chk("R6 left", pending, 8'hD0);
    step();
    chk("R10 no nest", take, 0);
    chk("R4 held", pending, 8'hD0);
    reti = 1'b1; step(); step();
    chk("R5 second", take_vec, 4);
    chk("R7 line4", pc_target, 16'h0020);
    reti = 1'b1; step(); step();
    chk("R5 third", take_vec, 6);
    chk("R7 line6", pc_target, 16'h0028);
    reti = 1'b1; step(); step();
    chk("R5 fourth", take_vec, 7);
    chk("R7 line7", pc_target, 16'h002C);
    chk("R6 all clear", pending, 0);
  endtask

  task automatic t_sw_dup();
    ext_req = 8'h08; sw_req = 1'b1; sw_vec = 3'd3; step();
    chk("R3 dup same line", pending, 8'h08);
    sw_req = 1'b1; sw_vec = 3'd0; step();
    chk("R3 line0 added", pending, 8'h09);
    reti = 1'b1; step(); step();
    chk("R5 line0 first", take_vec, 0);
    chk("R7 line0", pc_target, 16'h0010);
    reti = 1'b1; step(); step();
    chk("R5 line3", take_vec, 3);
    chk("R7 line3", pc_target, 16'h001C);
  endtask

  task automatic t_collide();
    reti = 1'b1; step();
    chk("R8 user idle", priv, 1);
    ext_req = 8'h02; step();
    chk("R2 user latch", pending, 8'h02);
    chk("R4 not yet", take, 0);
    cur_pc = 16'h0777; reti = 1'b1; ipc_wr = 1'b1; ipc_wdata = 16'hBEEF; step();
    chk("R10 take wins", take, 1);
    chk("R10 priv system", priv, 0);
    chk("R10 target vec", pc_target, 16'h0014);
    chk("R9 take over write", ipc_rdata, 16'h0777);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(3*CLK_PERIOD + 1);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_held_then_taken();
    t_priority();
    t_sw_dup();
    t_collide();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule